// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block is a clocked model of the command side of a parallel NOR flash. A host drives a bus made of chip enable, write enable, output enable, an active-low hardware reset and a byte/word select. Writes are taken by the command register. Multi-write sequences start timed program and erase operations on a small internal array. Reads return one of three things: array data, identification codes, or operation status, depending on the command state.

Operations run for a fixed number of clock cycles, each set by a parameter. While one runs, the ready output is low and reads return polling status. An erase can be suspended so that other sectors can be read and programmed, and then resumed. A fast program mode needs only two writes per program. Sector protection is an input vector that the surrounding logic or testbench drives.

Top module: `nor_flash_cmd`

## Requirements
- R1: After a hardware reset with no operation running, the block is in array-read mode. It reads the array with no command, and ready is high on the first cycle after release.
- R2: Program is four writes: AAh@555h, 55h@2AAh, A0h@555h, then data@address. Ready is low for exactly PROG_CYC cycles after the data write.
- R3: A program stores the AND of the old word and the written word, so a program can clear bits but never set them.
- R4: While a program, erase window or erase runs, a read at any address returns status instead of array data. Bit 7 is the complement of bit 7 of the programmed data (0 during erase). Bit 6 flips on every new read. All other bits are 0.
- R5: Chip erase is AAh,55h,80h,AAh,55h,10h. Sector erase ends in 30h written to an address in the sector. Further 30h writes within WIN_CYC cycles add sectors. Erased words read FFFFh. Sectors with their bit set in `prot` are neither erased nor programmed. A rejected program leaves ready high.
- R6: B0h during an erase suspends it and raises ready. While suspended, sectors not being erased read and program normally. Reads of an erasing sector return status with bit 7 = 1 and a toggling bit 6. A program aimed at an erasing sector is dropped. 30h resumes the erase.
- R7: AAh,55h,20h enters fast program mode. There, A0h followed by data@address programs. 90h followed by 00h leaves the mode.
- R8: AAh,55h,90h enters identification mode. Address bits {A6,A1,A0}=000 read 0001h. A0=1 reads 22C4h (TOP_BOOT=1) or 2249h. A1=1 with A0=0 reads 0001h if the addressed sector is protected and 0000h if not. Any write returns to array read.
- R9: A write that breaks a command sequence (wrong data or address) returns to array-read mode and leaves the array unchanged.
- R10: While reset is low, data outputs are disabled and bus writes are ignored. A reset that hits a running or suspended operation aborts it, leaves the array unchanged, and holds ready low for exactly RST_CYC cycles after release.
- R11: With `word_mode`=0 only data lane 7:0 is enabled. `dq_in[15]` acts as the byte address bit: 0 selects the low byte and 1 the high byte of the array word, for both read and program. Status and identification reads give their low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Active-low hardware reset, also the power-on reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data; bit 15 is the byte address in byte mode |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Output enable per lane: bit 1 for 15:8, bit 0 for 7:0 |
| ready | output | 1 | High when no operation or internal reset is in progress |
| prot | input | 2**SEC_W | Per-sector protection, 1 = protected |

## Verification
The assertions assume that `prot` does not change while an erase is selected or running, and that a write lasts at least one cycle with write enable released between writes. The bench changes `prot` only after ready has returned high with no erase suspended. Every write strobe is one cycle, followed by one released cycle. Array contents are undefined before the first chip erase, so the bench erases the whole array before it compares any array data.

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd #(
  parameter int ADDR_W    = 11,
  parameter int MEM_AW    = 6,
  parameter int SEC_W     = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 48,
  parameter int WIN_CYC   = 6,
  parameter int RST_CYC   = 5,
  parameter int CNT_W     = 16,
  parameter bit TOP_BOOT  = 1'b1
) (
  input  logic                    clk,
  input  logic                    hw_rst_n,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic                    word_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [15:0]             dq_in,
  output logic [15:0]             dq_out,
  output logic [1:0]              dq_oe,
  output logic                    ready,
  input  logic [(1<<SEC_W)-1:0]   prot
);

  localparam int WORDS  = 1 << MEM_AW;
  localparam int NSEC   = 1 << SEC_W;
  localparam int SEC_SH = MEM_AW - SEC_W;

  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PDATA, ST_PROG, ST_E0, ST_E1, ST_E2,
    ST_EWIN, ST_ERASE, ST_ASEL, ST_BYP, ST_BPDATA, ST_BEXIT, ST_ABORT
  } st_t;

  logic [15:0]       mem [WORDS];
  st_t               st;
  logic              sus, byp, tog, wr_q, rd_q, pbit;
  logic [CNT_W-1:0]  pcnt, ecnt;
  logic [NSEC-1:0]   esel;
  logic [MEM_AW-1:0] pidx;
  logic [15:0]       pdat;

  logic              wr_act, rd_act, wr, rd_start;
  logic [MEM_AW-1:0] idx;
  logic [SEC_W-1:0]  sec;
  logic [NSEC-1:0]   sec_hot;
  logic [7:0]        cmd;
  logic              a555, a2aa, lsb, prog_ok, prog_done, erase_done, op_busy, do_susp;
  logic [15:0]       bdat, stat, id_w, src;
  logic              stat_sel, arr_src;

  assign wr_act   = hw_rst_n & ~ce_n & ~we_n & oe_n;
  assign rd_act   = hw_rst_n & ~ce_n & ~oe_n & we_n;
  assign wr       = wr_act & ~wr_q;
  assign rd_start = rd_act & ~rd_q;
  assign idx      = addr[MEM_AW-1:0];
  assign sec      = addr[MEM_AW-1 -: SEC_W];
  assign sec_hot  = NSEC'(1) << sec;
  assign cmd      = dq_in[7:0];
  assign a555     = addr == ADDR_W'('h555);
  assign a2aa     = addr == ADDR_W'('h2AA);
  assign lsb      = dq_in[15];
  assign bdat     = word_mode ? dq_in : (lsb ? {dq_in[7:0], 8'hFF} : {8'hFF, dq_in[7:0]});
  assign prog_ok  = !prot[sec] && !(sus && esel[sec]);
  assign do_susp  = wr && cmd == 8'hB0;
  assign prog_done  = hw_rst_n && st == ST_PROG && pcnt == '0;
  assign erase_done = hw_rst_n && st == ST_ERASE && ecnt == '0 && !do_susp;
  assign op_busy  = st == ST_PROG || st == ST_EWIN || st == ST_ERASE || st == ST_ABORT || sus;
  assign ready    = !(st == ST_PROG || st == ST_EWIN || st == ST_ERASE || st == ST_ABORT);

  always_ff @(posedge clk) begin
    if (!hw_rst_n) begin
      st   <= op_busy ? ST_ABORT : ST_READ;
      pcnt <= CNT_W'(RST_CYC - 1);
      ecnt <= '0;
      esel <= '0;
      sus  <= 1'b0;
      byp  <= 1'b0;
      tog  <= 1'b0;
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (rd_start) tog <= ~tog;
      case (st)
        ST_READ: if (wr) begin
          if (sus && cmd == 8'h30) begin
            st  <= ST_ERASE;
            sus <= 1'b0;
          end else if (cmd == 8'hAA && a555) st <= ST_U1;
        end
        ST_U1: if (wr) st <= (cmd == 8'h55 && a2aa) ? ST_U2 : ST_READ;
        ST_U2: if (wr) begin
          st <= ST_READ;
          if (a555) begin
            case (cmd)
              8'hA0: st <= ST_PDATA;
              8'h80: if (!sus) st <= ST_E0;
              8'h90: if (!sus) st <= ST_ASEL;
              8'h20: if (!sus) begin
                st  <= ST_BYP;
                byp <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_PDATA, ST_BPDATA: if (wr) begin
          if (prog_ok) begin
            st   <= ST_PROG;
            pcnt <= CNT_W'(PROG_CYC - 1);
            pidx <= idx;
            pdat <= bdat;
            pbit <= dq_in[7];
          end else begin
            st <= (st == ST_BPDATA) ? ST_BYP : ST_READ;
          end
        end
        ST_PROG: begin
          if (pcnt == '0) st <= byp ? ST_BYP : ST_READ;
          else pcnt <= pcnt - CNT_W'(1);
        end
        ST_E0: if (wr) st <= (cmd == 8'hAA && a555) ? ST_E1 : ST_READ;
        ST_E1: if (wr) st <= (cmd == 8'h55 && a2aa) ? ST_E2 : ST_READ;
        ST_E2: if (wr) begin
          if (a555 && cmd == 8'h10) begin
            if (|(~prot)) begin
              st   <= ST_ERASE;
              esel <= ~prot;
              ecnt <= CNT_W'(ERASE_CYC - 1);
            end else st <= ST_READ;
          end else if (cmd == 8'h30) begin
            st   <= ST_EWIN;
            esel <= sec_hot & ~prot;
            ecnt <= CNT_W'(WIN_CYC - 1);
          end else st <= ST_READ;
        end
        ST_EWIN: begin
          if (wr) begin
            if (cmd == 8'h30) begin
              esel <= esel | (sec_hot & ~prot);
              ecnt <= CNT_W'(WIN_CYC - 1);
            end else begin
              st   <= ST_READ;
              esel <= '0;
            end
          end else if (ecnt == '0) begin
            if (|esel) begin
              st   <= ST_ERASE;
              ecnt <= CNT_W'(ERASE_CYC - 1);
            end else st <= ST_READ;
          end else ecnt <= ecnt - CNT_W'(1);
        end
        ST_ERASE: begin
          if (do_susp) begin
            st  <= ST_READ;
            sus <= 1'b1;
          end else if (ecnt == '0) begin
            st   <= ST_READ;
            esel <= '0;
          end else ecnt <= ecnt - CNT_W'(1);
        end
        ST_ASEL: if (wr) st <= ST_READ;
        ST_BYP: if (wr) begin
          if (cmd == 8'hA0) st <= ST_BPDATA;
          else if (cmd == 8'h90) st <= ST_BEXIT;
        end
        ST_BEXIT: if (wr) begin
          if (cmd == 8'h00) begin
            st  <= ST_READ;
            byp <= 1'b0;
          end else st <= ST_BYP;
        end
        ST_ABORT: begin
          if (pcnt == '0) st <= ST_READ;
          else pcnt <= pcnt - CNT_W'(1);
        end
        default: st <= ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (prog_done) mem[pidx] <= mem[pidx] & pdat;
    if (erase_done)
      for (int unsigned w = 0; w < WORDS; w++)
        if (esel[w >> SEC_SH]) mem[w] <= '1;
  end

  assign stat_sel = st == ST_PROG || st == ST_EWIN || st == ST_ERASE || (sus && esel[sec]);
  assign arr_src  = !stat_sel && st != ST_ASEL;
  assign stat     = {8'h00, (st == ST_PROG) ? ~pbit : sus, tog, 6'h00};

  always_comb begin
    if (addr[1:0] == 2'b00) id_w = addr[6] ? 16'h0000 : 16'h0001;
    else if (addr[0])       id_w = TOP_BOOT ? 16'h22C4 : 16'h2249;
    else                    id_w = {15'h0000, prot[sec]};
    if (stat_sel)            src = stat;
    else if (st == ST_ASEL)  src = id_w;
    else                     src = mem[idx];
    if (word_mode) dq_out = src;
    else           dq_out = {8'h00, (arr_src && lsb) ? src[15:8] : src[7:0]};
  end

  assign dq_oe = {rd_act & word_mode, rd_act};

  assert_prog_busy_R2: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (st == ST_PDATA && wr && prog_ok) |=> !ready);
  assert_clear_only_R3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    prog_done |=> ((mem[$past(pidx)] & ~$past(pdat)) == '0));
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (st == ST_PROG && pcnt != '0) |=> !ready);
  assert_prot_excluded_R5: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (st == ST_ERASE) |-> ((esel & prot) == '0));
  assert_suspend_ready_R6: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (st == ST_ERASE && do_susp) |=> (sus && ready));
  assert_abort_busy_R10: assert property (@(posedge clk)
    (!hw_rst_n && st == ST_ERASE) |=> !ready);

endmodule

// File: tb/test_nor_flash_cmd.sv
`timescale 1ns/1ps
module test_nor_flash_cmd;
  localparam int PROG_CYC = 8, ERASE_CYC = 48, WIN_CYC = 6, RST_CYC = 5;

  logic clk = 1'b0, hw_rst_n, ce_n, we_n, oe_n, word_mode, ready;
  logic [10:0] addr;
  logic [15:0] dq_in, dq_out;
  logic [1:0]  dq_oe;
  logic [3:0]  prot;
  logic [15:0] refm [64];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  nor_flash_cmd #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC),
                  .RST_CYC(RST_CYC)) i_nor_flash_cmd (
    .clk(clk), .hw_rst_n(hw_rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .word_mode(word_mode), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .ready(ready), .prot(prot));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic brd(input logic [10:0] a, input logic hi, output logic [15:0] q, output logic [1:0] oe);
    @(negedge clk);
    addr = a; dq_in = {hi, 15'h0000}; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(posedge clk);
    #1;
    q = dq_out; oe = dq_oe;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!ready && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk(n < 5000, "R2 ready timeout", 16'(n), 16'd0);
  endtask

  task automatic unlock();
    bwr(11'h555, 16'h00AA);
    bwr(11'h2AA, 16'h0055);
  endtask

  task automatic prog(input logic [10:0] a, input logic [15:0] d);
    int n;
    unlock();
    bwr(11'h555, 16'h00A0);
    bwr(a, d);
    wait_rdy(n);
  endtask

  task automatic erase_cmd();
    unlock();
    bwr(11'h555, 16'h0080);
    unlock();
  endtask

  task automatic sweep(input string req);
    logic [15:0] q;
    logic [1:0] oe;
    for (int i = 0; i < 64; i++) begin
      brd(11'(i), 1'b0, q, oe);
      chk(q == refm[i] && oe == 2'b11, req, q, refm[i]);
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] q, q2;
    logic [1:0] oe;
    int n;
    hw_rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; word_mode = 1'b1;
    addr = '0; dq_in = '0; prot = 4'h0;
    repeat (3) @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk); #1;
    chk(dq_oe == 2'b00, "R10 outputs off in reset", 16'(dq_oe), 16'h0);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; hw_rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", 16'(ready), 16'h1);

    // R5 chip erase with status read during the erase
    erase_cmd();
    bwr(11'h555, 16'h0010);
    brd(11'h000, 1'b0, q, oe);
    chk((q & 16'hFFBF) == 16'h0000 && !ready, "R4 erase status", q, 16'h0000);
    wait_rdy(n);
    for (int i = 0; i < 64; i++) refm[i] = 16'hFFFF;
    sweep("R5 chip erase");

    // R2 busy length, R4 program status
    unlock(); bwr(11'h555, 16'h00A0); bwr(11'h000, 16'h1234);
    wait_rdy(n);
    chk(n == PROG_CYC, "R2 busy cycles", 16'(n), 16'(PROG_CYC));
    refm[0] = 16'h1234;
    unlock(); bwr(11'h555, 16'h00A0); bwr(11'h001, 16'h4321);
    brd(11'h030, 1'b0, q, oe);
    brd(11'h001, 1'b0, q2, oe);
    chk(q[7] == 1'b1 && (q & 16'hFF3F) == 16'h0 && !ready, "R4 polling bit", q, 16'h0080);
    chk(q[6] != q2[6], "R4 toggle bit", q2, q ^ 16'h0040);
    wait_rdy(n);
    refm[1] = 16'h4321;
    for (int i = 2; i < 32; i++) begin
      refm[i] = 16'(i * 16'h0971) ^ 16'hA5C3;
      prog(11'(i), refm[i]);
    end

    // R7 fast program mode
    unlock(); bwr(11'h555, 16'h0020);
    for (int i = 32; i < 64; i++) begin
      refm[i] = 16'(i * 16'h0971) ^ 16'hA5C3;
      bwr(11'h7F0, 16'h00A0);
      bwr(11'(i), refm[i]);
      wait_rdy(n);
    end
    bwr(11'h000, 16'h0090); bwr(11'h000, 16'h0000);
    sweep("R2 R7 programmed array");
    bwr(11'h028, 16'h00A0); bwr(11'h028, 16'h0000);
    brd(11'h028, 1'b0, q, oe);
    chk(q == refm[40] && ready, "R7 mode left", q, refm[40]);

    // R9 broken sequences
    unlock(); bwr(11'h555, 16'h0077); bwr(11'h555, 16'h00A0); bwr(11'h005, 16'h0000);
    brd(11'h005, 1'b0, q, oe);
    chk(q == refm[5] && ready, "R9 bad command", q, refm[5]);
    bwr(11'h555, 16'h00AA); bwr(11'h123, 16'h0055); bwr(11'h555, 16'h00A0); bwr(11'h006, 16'h0000);
    brd(11'h006, 1'b0, q, oe);
    chk(q == refm[6] && ready, "R9 bad unlock address", q, refm[6]);

    // R3 AND behaviour
    prog(11'h003, 16'hF00F);
    refm[3] = refm[3] & 16'hF00F;
    brd(11'h003, 1'b0, q, oe);
    chk(q == refm[3], "R3 clear only", q, refm[3]);

    // R8 identification, R11 byte lane
    prot = 4'b0100;
    unlock(); bwr(11'h555, 16'h0090);
    brd(11'h000, 1'b0, q, oe);
    chk(q == 16'h0001, "R8 maker code", q, 16'h0001);
    brd(11'h001, 1'b0, q, oe);
    chk(q == 16'h22C4, "R8 device code", q, 16'h22C4);
    brd(11'h040, 1'b0, q, oe);
    chk(q == 16'h0000, "R8 A6 set", q, 16'h0000);
    for (int s = 0; s < 4; s++) begin
      brd(11'((s << 4) | 2), 1'b0, q, oe);
      chk(q == {15'h0, prot[s]}, "R8 protect code", q, {15'h0, prot[s]});
    end
    word_mode = 1'b0;
    brd(11'h001, 1'b0, q, oe);
    chk(q == 16'h00C4 && oe == 2'b01, "R11 byte device code", q, 16'h00C4);
    word_mode = 1'b1;
    bwr(11'h000, 16'h00F0);
    brd(11'h000, 1'b0, q, oe);
    chk(q == refm[0], "R8 exit to array", q, refm[0]);

    // R5 protection and multi-sector erase
    unlock(); bwr(11'h555, 16'h00A0); bwr(11'h025, 16'h0000);
    chk(ready == 1'b1, "R5 protected program rejected", 16'(ready), 16'h1);
    brd(11'h025, 1'b0, q, oe);
    chk(q == refm[37], "R5 protected word kept", q, refm[37]);
    erase_cmd();
    bwr(11'h010, 16'h0030); bwr(11'h020, 16'h0030);
    wait_rdy(n);
    for (int i = 16; i < 32; i++) refm[i] = 16'hFFFF;
    sweep("R5 sector erase");
    erase_cmd();
    bwr(11'h555, 16'h0010);
    wait_rdy(n);
    for (int i = 0; i < 64; i++) if (i < 32 || i >= 48) refm[i] = 16'hFFFF;
    sweep("R5 chip erase with protection");
    prot = 4'h0;

    // R6 suspend and resume
    prog(11'h003, 16'h1234); refm[3] = 16'h1234;
    prog(11'h033, 16'hF0F0); refm[51] = 16'hF0F0;
    erase_cmd();
    bwr(11'h000, 16'h0030);
    repeat (WIN_CYC + 4) @(negedge clk);
    bwr(11'h000, 16'h00B0);
    chk(ready == 1'b1, "R6 ready when suspended", 16'(ready), 16'h1);
    brd(11'h033, 1'b0, q, oe);
    chk(q == 16'hF0F0, "R6 other sector readable", q, 16'hF0F0);
    brd(11'h003, 1'b0, q, oe);
    brd(11'h003, 1'b0, q2, oe);
    chk(q[7] && (q & 16'hFF3F) == 16'h0 && q[6] != q2[6], "R6 erasing sector status", q, q2 ^ 16'h0040);
    prog(11'h034, 16'h0F0F); refm[52] = refm[52] & 16'h0F0F;
    brd(11'h034, 1'b0, q, oe);
    chk(q == refm[52], "R6 program while suspended", q, refm[52]);
    unlock(); bwr(11'h555, 16'h00A0); bwr(11'h005, 16'h0000);
    chk(ready == 1'b1, "R6 program to erasing sector dropped", 16'(ready), 16'h1);
    bwr(11'h000, 16'h0030);
    chk(ready == 1'b0, "R6 resumed busy", 16'(ready), 16'h0);
    wait_rdy(n);
    for (int i = 0; i < 16; i++) refm[i] = 16'hFFFF;
    sweep("R6 erase finished after resume");

    // R10 reset abort
    erase_cmd();
    bwr(11'h030, 16'h0030);
    repeat (WIN_CYC + 6) @(negedge clk);
    hw_rst_n = 1'b0;
    addr = 11'h555; dq_in = 16'h00AA; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; oe_n = 1'b0;
    @(posedge clk); #1;
    chk(dq_oe == 2'b00, "R10 outputs off while held", 16'(dq_oe), 16'h0);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; hw_rst_n = 1'b1;
    n = 0;
    while (!ready && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == RST_CYC, "R10 internal reset time", 16'(n), 16'(RST_CYC));
    bwr(11'h2AA, 16'h0055); bwr(11'h555, 16'h00A0); bwr(11'h035, 16'h0000);
    chk(ready == 1'b1, "R10 write in reset ignored", 16'(ready), 16'h1);
    sweep("R10 array kept after abort");
    hw_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    hw_rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 idle reset no busy", 16'(ready), 16'h1);

    // R11 byte mode read and program
    word_mode = 1'b0;
    brd(11'h022, 1'b0, q, oe);
    chk(q == {8'h00, refm[34][7:0]} && oe == 2'b01, "R11 low byte", q, {8'h00, refm[34][7:0]});
    brd(11'h022, 1'b1, q, oe);
    chk(q == {8'h00, refm[34][15:8]} && oe == 2'b01, "R11 high byte", q, {8'h00, refm[34][15:8]});
    prog(11'h022, 16'h803C);
    refm[34] = refm[34] & 16'h3CFF;
    word_mode = 1'b1;
    brd(11'h022, 1'b0, q, oe);
    chk(q == refm[34], "R11 byte program", q, refm[34]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule